// File: doc/BRIEF.md
# Banked program memory decoder

This block sits on the CPU side of an 8-bit console cartridge. It watches the CPU address bus, the read/write line, the ROM-select strobe and the M2 phase clock, and from these it drives the upper address lines of a 256 KB program ROM, the ROM chip enable, and the chip selects of two 8 KB work RAM chips (chip A and chip B). Four bank registers, written by the CPU through a small register window, decide what each CPU window shows.

The CPU space from $8000 to $BFFF is split into two 8 KB switchable windows. Each can show any 8 KB ROM bank or either RAM chip. The window at $C000 always shows a selectable ROM bank, and the window at $E000 always shows the last ROM bank. The $6000-$7FFF range always shows RAM, and a register chooses the chip.

Register writes pass through a three-state bus-phase machine that runs on a fast system clock. It samples M2 synchronously. State PH_LOW means M2 is low. State PH_HIGH means M2 is high and no register write has been seen. State PH_ARMED means a register write was captured during the current high phase. The transitions are: PH_LOW to PH_ARMED on M2 high with a register write present. PH_LOW to PH_HIGH on M2 high without one. PH_HIGH to PH_ARMED when a register write appears. PH_HIGH to PH_LOW when M2 falls. PH_ARMED to PH_LOW when M2 falls, and this last transition commits the captured value. While in PH_ARMED, a later register write in the same high phase replaces the captured value.

Top module: `prg_bank_decoder`

## Requirements
- R1: After reset all four bank registers read as zero. So the $8000 and $A000 windows select RAM chip A with the ROM enable high, the $C000 window shows ROM bank 0, and $6000-$7FFF with M2 high selects chip A.
- R2: A register write is a cycle with M2 high, ROM-select high, read/write low, address bits [15:12]=0100, bit 10=1 and bits [5:4]=00. Address bits [1:0] pick register 0 ($8000 window), 1 ($A000 window), 2 ($C000 window) or 3 ($6000 RAM). Bits 11, 9-6 and 3-2 are ignored, so $44xx and $4Cxx mirror each other.
- R3: A CPU cycle that misses the R2 decode leaves every register unchanged. Examples are bit 10 = 0, bits [5:4] nonzero, bit 12 = 1, a read cycle, or ROM-select low.
- R4: A register takes the data of the last decoded write seen during one M2 high phase, at the first clock edge at which M2 is sampled low, and not before.
- R5: In the $8000 ($A000) window, when bit 7 of register 0 (1) is 1, rom_bank equals the register's bits [4:0], rom_ce_n is low, and both RAM selects are high.
- R6: In the same windows, when bit 7 is 0, rom_ce_n is high and rom_bank is 0. Bit 2 selects the RAM chip: 0 drives ram_a_cs_n low, 1 drives ram_b_cs_n low.
- R7: The $C000-$DFFF window (ROM-select low, address bits [14:13]=10) always shows ROM, with rom_bank equal to bits [4:0] of register 2.
- R8: The $E000-$FFFF window (ROM-select low, bits [14:13]=11) drives rom_bank to all ones with rom_ce_n low.
- R9: For ROM-select high and address bits [15:13]=011, a RAM select is low only while M2 is high. Bit 2 of register 3 picks chip A (0) or chip B (1), and rom_ce_n stays high.
- R10: Any other cycle drives rom_ce_n, ram_a_cs_n and ram_b_cs_n high and rom_bank to 0.
- R11: At most one of rom_ce_n, ram_a_cs_n and ram_b_cs_n is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than M2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (write data) |
| cpu_rw | input | 1 | CPU read/write, 1 = read |
| romsel_n | input | 1 | ROM-select strobe, low for $8000-$FFFF accesses |
| m2 | input | 1 | CPU phase clock |
| rom_bank | output | 5 | Program ROM address lines 17..13 |
| rom_ce_n | output | 1 | Program ROM chip enable, active low |
| ram_a_cs_n | output | 1 | Work RAM chip A select, active low |
| ram_b_cs_n | output | 1 | Work RAM chip B select, active low |

## Verification
A wrong bank register or a lost commit shows up as a wrong rom_bank or a wrong chip select on the very next access to the affected window. It can hide until that window is read, so every register value is followed at once by probes of all windows. A phase machine that commits early or late shows as rom_bank changing one clock away from the first clock edge with M2 low. The bench samples on both sides of that edge. A write leaking through a missed decode shows as a changed $C000 bank on the probe that follows the stray cycle.

// File: rtl/prg_dec_pkg.sv
package prg_dec_pkg;

    typedef enum logic [1:0] {
        PH_LOW   = 2'd0,
        PH_HIGH  = 2'd1,
        PH_ARMED = 2'd2
    } bus_phase_e;

    typedef enum logic [2:0] {
        WIN_IDLE = 3'd0,
        WIN_WRAM = 3'd1,
        WIN_LOW0 = 3'd2,
        WIN_LOW1 = 3'd3,
        WIN_MID  = 3'd4,
        WIN_TOP  = 3'd5
    } win_e;

    localparam int REG_COUNT  = 4;
    localparam int REG_IDX_W  = 2;
    localparam int ROM_FLAG_B = 7;
    localparam int CHIP_B     = 2;

endpackage

// File: rtl/prg_bus_fsm.sv
module prg_bus_fsm
    import prg_dec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 m2,
    input  logic                 reg_hit,
    input  logic [REG_IDX_W-1:0] hit_idx,
    input  logic [DATA_W-1:0]    hit_data,
    output logic                 commit_stb,
    output logic [REG_IDX_W-1:0] cap_idx,
    output logic [DATA_W-1:0]    cap_data
);

    bus_phase_e state_q, state_d;
    logic       capture_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        commit_stb = 1'b0;
        capture_en = 1'b0;
        unique case (state_q)
            PH_LOW: begin
                if (m2 && reg_hit) begin
                    state_d    = PH_ARMED;
                    capture_en = 1'b1;
                end else if (m2) begin
                    state_d = PH_HIGH;
                end
            end
            PH_HIGH: begin
                if (!m2) begin
                    state_d = PH_LOW;
                end else if (reg_hit) begin
                    state_d    = PH_ARMED;
                    capture_en = 1'b1;
                end
            end
            PH_ARMED: begin
                if (!m2) begin
                    state_d    = PH_LOW;
                    commit_stb = 1'b1;
                end else if (reg_hit) begin
                    capture_en = 1'b1;
                end
            end
            default: begin
                state_d = PH_LOW;
            end
        endcase
    end

    // capture of the latest decoded write in this high phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_idx  <= '0;
            cap_data <= '0;
        end else if (capture_en) begin
            cap_idx  <= hit_idx;
            cap_data <= hit_data;
        end
    end

endmodule

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
    import prg_dec_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BANK_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit_stb,
    input  logic [REG_IDX_W-1:0]          cap_idx,
    input  logic [DATA_W-1:0]             cap_data,
    output logic [1:0]                    win_rom,
    output logic [2:0][BANK_W-1:0]        win_bank,
    output logic [2:0]                    chip_q
);

    localparam int BANK_REGS = 3;
    localparam int FLAG_REGS = 2;

    // bank fields: registers 0, 1, 2
    for (genvar i = 0; i < BANK_REGS; i++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                win_bank[i] <= '0;
            end else if (commit_stb && (cap_idx == REG_IDX_W'(i))) begin
                win_bank[i] <= cap_data[BANK_W-1:0];
            end
        end
    end

    // ROM/RAM flag and chip bit: registers 0, 1
    for (genvar i = 0; i < FLAG_REGS; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                win_rom[i] <= 1'b0;
                chip_q[i]  <= 1'b0;
            end else if (commit_stb && (cap_idx == REG_IDX_W'(i))) begin
                win_rom[i] <= cap_data[ROM_FLAG_B];
                chip_q[i]  <= cap_data[CHIP_B];
            end
        end
    end

    // chip bit of register 3 (work RAM window)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chip_q[2] <= 1'b0;
        end else if (commit_stb && (cap_idx == REG_IDX_W'(REG_COUNT - 1))) begin
            chip_q[2] <= cap_data[CHIP_B];
        end
    end

endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
    import prg_dec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 5
) (
    input  logic                   romsel_n,
    input  logic                   m2,
    input  logic [ADDR_W-1:13]     addr_hi,
    input  logic [1:0]             win_rom,
    input  logic [2:0][BANK_W-1:0] win_bank,
    input  logic [2:0]             chip_q,
    output logic [BANK_W-1:0]      rom_bank,
    output logic                   rom_ce_n,
    output logic                   ram_a_cs_n,
    output logic                   ram_b_cs_n
);

    win_e win;

    // classify the access
    always_comb begin
        win = WIN_IDLE;
        if (!romsel_n) begin
            unique case (addr_hi[14:13])
                2'b00:   win = WIN_LOW0;
                2'b01:   win = WIN_LOW1;
                2'b10:   win = WIN_MID;
                default: win = WIN_TOP;
            endcase
        end else if (m2 && (addr_hi[15:13] == 3'b011)) begin
            win = WIN_WRAM;
        end
    end

    // drive ROM lines and chip selects
    always_comb begin
        rom_bank   = '0;
        rom_ce_n   = 1'b1;
        ram_a_cs_n = 1'b1;
        ram_b_cs_n = 1'b1;
        unique case (win)
            WIN_LOW0, WIN_LOW1: begin
                if (win_rom[win == WIN_LOW1]) begin
                    rom_bank = win_bank[win == WIN_LOW1];
                    rom_ce_n = 1'b0;
                end else begin
                    ram_a_cs_n =  chip_q[win == WIN_LOW1];
                    ram_b_cs_n = ~chip_q[win == WIN_LOW1];
                end
            end
            WIN_MID: begin
                rom_bank = win_bank[2];
                rom_ce_n = 1'b0;
            end
            WIN_TOP: begin
                rom_bank = '1;
                rom_ce_n = 1'b0;
            end
            WIN_WRAM: begin
                ram_a_cs_n =  chip_q[2];
                ram_b_cs_n = ~chip_q[2];
            end
            default: begin
                rom_bank = '0;
            end
        endcase
    end

endmodule

// File: rtl/prg_bank_decoder.sv
module prg_bank_decoder
    import prg_dec_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int ROM_BANKS = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             cpu_addr,
    input  logic [DATA_W-1:0]             cpu_data,
    input  logic                          cpu_rw,
    input  logic                          romsel_n,
    input  logic                          m2,
    output logic [$clog2(ROM_BANKS)-1:0]  rom_bank,
    output logic                          rom_ce_n,
    output logic                          ram_a_cs_n,
    output logic                          ram_b_cs_n
);

    localparam int BANK_W = $clog2(ROM_BANKS);

    logic                   reg_hit;
    logic                   commit_stb;
    logic [REG_IDX_W-1:0]   cap_idx;
    logic [DATA_W-1:0]      cap_data;
    logic [1:0]             win_rom;
    logic [2:0][BANK_W-1:0] win_bank;
    logic [2:0]             chip_q;
    logic                   unused_bits;

    // register window: $4400-$47FF mirrored at $4C00-$4FFF, A5:A4 = 00
    assign reg_hit = m2 && romsel_n && !cpu_rw
                  && (cpu_addr[15:12] == 4'b0100)
                  && cpu_addr[10]
                  && (cpu_addr[5:4] == 2'b00);

    assign unused_bits = ^{cpu_addr[11], cpu_addr[9:6], cpu_addr[3:2],
                           cap_data[DATA_W-2:BANK_W]};

    prg_bus_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .m2         (m2),
        .reg_hit    (reg_hit),
        .hit_idx    (cpu_addr[REG_IDX_W-1:0]),
        .hit_data   (cpu_data),
        .commit_stb (commit_stb),
        .cap_idx    (cap_idx),
        .cap_data   (cap_data)
    );

    prg_bank_regs #(
        .DATA_W (DATA_W),
        .BANK_W (BANK_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_stb (commit_stb),
        .cap_idx    (cap_idx),
        .cap_data   (cap_data),
        .win_rom    (win_rom),
        .win_bank   (win_bank),
        .chip_q     (chip_q)
    );

    prg_window_map #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W)
    ) u_map (
        .romsel_n   (romsel_n),
        .m2         (m2),
        .addr_hi    (cpu_addr[ADDR_W-1:13]),
        .win_rom    (win_rom),
        .win_bank   (win_bank),
        .chip_q     (chip_q),
        .rom_bank   (rom_bank),
        .rom_ce_n   (rom_ce_n),
        .ram_a_cs_n (ram_a_cs_n),
        .ram_b_cs_n (ram_b_cs_n)
    );

endmodule

// File: rtl/prg_bank_decoder_chk.sv
module prg_bank_decoder_chk #(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      cpu_addr,
    input logic                   romsel_n,
    input logic                   m2,
    input logic [BANK_W-1:0]      rom_bank,
    input logic                   rom_ce_n,
    input logic                   ram_a_cs_n,
    input logic                   ram_b_cs_n,
    input logic                   commit_stb,
    input logic [1:0]             win_rom,
    input logic [2:0][BANK_W-1:0] win_bank,
    input logic [2:0]             chip_q
);

    // R11: never two devices enabled together
    p_one_device_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~rom_ce_n, ~ram_a_cs_n, ~ram_b_cs_n}));

    // R8: top window is the last ROM bank
    p_top_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!romsel_n && (cpu_addr[14:13] == 2'b11)) |-> ((rom_bank == '1) && !rom_ce_n));

    // R9 / R10: no device selected outside ROM cycles while M2 is low
    p_idle_when_m2_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (romsel_n && !m2) |-> (rom_ce_n && ram_a_cs_n && ram_b_cs_n));

    // R4: registers move only on a commit
    p_hold_without_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_stb |=> $stable({win_rom, win_bank, chip_q}));

    // R4: a commit happens only on the first low sample after a high phase
    p_commit_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |-> ($past(m2) && !m2));

endmodule

bind prg_bank_decoder prg_bank_decoder_chk #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .romsel_n   (romsel_n),
    .m2         (m2),
    .rom_bank   (rom_bank),
    .rom_ce_n   (rom_ce_n),
    .ram_a_cs_n (ram_a_cs_n),
    .ram_b_cs_n (ram_b_cs_n),
    .commit_stb (commit_stb),
    .win_rom    (win_rom),
    .win_bank   (win_bank),
    .chip_q     (chip_q)
);

// File: tb/prg_bank_decoder_bench.sv
`timescale 1ns/1ps
module prg_bank_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_rw = 1'b1;
    logic        romsel_n = 1'b1;
    logic        m2 = 1'b0;
    logic [4:0]  rom_bank;
    logic        rom_ce_n, ram_a_cs_n, ram_b_cs_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] mreg [4];

    always #2.5 clk = ~clk;

    prg_bank_decoder u_prg_bank_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .romsel_n(romsel_n), .m2(m2), .rom_bank(rom_bank),
        .rom_ce_n(rom_ce_n), .ram_a_cs_n(ram_a_cs_n), .ram_b_cs_n(ram_b_cs_n)
    );

    function automatic logic [7:0] expect_out(input logic [15:0] a,
                                              input logic rs, input logic ph);
        logic [7:0] r;
        if (!rs) begin
            case (a[14:13])
                2'b11: return {5'd31, 3'b011};
                2'b10: return {mreg[2][4:0], 3'b011};
                default: begin
                    r = mreg[a[13]];
                    if (r[7]) return {r[4:0], 3'b011};
                    return {5'd0, 1'b1, r[2], ~r[2]};
                end
            endcase
        end
        if (ph && a[15:13] == 3'b011) return {5'd0, 1'b1, mreg[3][2], ~mreg[3][2]};
        return {5'd0, 3'b111};
    endfunction

    task automatic compare(input string tag, input logic [7:0] exp);
        logic [7:0] got;
        got = {rom_bank, rom_ce_n, ram_a_cs_n, ram_b_cs_n};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s addr=%h got=%h expected=%h", tag, cpu_addr, got, exp);
        end
    endtask

    task automatic probe(input logic [15:0] a, input logic rs, input logic ph,
                         input string tag);
        @(negedge clk);
        cpu_addr = a; romsel_n = rs; m2 = ph; cpu_rw = 1'b1;
        #1;
        compare(tag, expect_out(a, rs, ph));
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d,
                             input logic rw, input logic rs);
        @(negedge clk);
        m2 = 1'b0; cpu_addr = a; cpu_data = d; cpu_rw = rw; romsel_n = rs;
        @(negedge clk);
        m2 = 1'b1;
        repeat (3) @(negedge clk);
        m2 = 1'b0;
        repeat (2) @(negedge clk);
        cpu_rw = 1'b1; romsel_n = 1'b1;
        if (rs && !rw && a[15:12] == 4'b0100 && a[10] && a[5:4] == 2'b00)
            mreg[a[1:0]] = d;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) mreg[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state in every window
        probe(16'h8000, 1'b0, 1'b1, "R1 low0 after reset");
        probe(16'hA123, 1'b0, 1'b1, "R1 low1 after reset");
        probe(16'hC000, 1'b0, 1'b1, "R1 mid after reset");
        probe(16'h6000, 1'b1, 1'b1, "R1 wram after reset");
        probe(16'hE000, 1'b0, 1'b1, "R8 top after reset");
        probe(16'h5000, 1'b1, 1'b1, "R10 idle after reset");

        // R5 R6 R7 R9: sweep every register value
        for (int d = 0; d < 256; d++) begin
            bus_write(16'h4C00, 8'(d), 1'b0, 1'b1);
            bus_write(16'h4401, 8'(d) ^ 8'h5A, 1'b0, 1'b1);
            bus_write(16'h4C02, 8'(d), 1'b0, 1'b1);
            bus_write(16'h4403, 8'(d), 1'b0, 1'b1);
            probe(16'h8000 | 16'(d), 1'b0, 1'b1, "R5 R6 window 8000");
            probe(16'hBFFF, 1'b0, 1'b1, "R5 R6 window A000");
            probe(16'hD000 | 16'(d), 1'b0, 1'b1, "R7 window C000");
            probe(16'hFFFF, 1'b0, 1'b1, "R8 window E000");
            probe(16'h7000 | 16'(d), 1'b1, 1'b1, "R9 wram M2 high");
            probe(16'h6000, 1'b1, 1'b0, "R9 wram M2 low");
            probe(16'h4C00, 1'b1, 1'b1, "R10 register space read");
            probe(16'h0000 | 16'(d), 1'b1, 1'b1, "R10 low memory");
            probe(16'h8000, 1'b0, 1'b1, "R11 one device");
        end

        // R2: mirror and ignored address bits
        bus_write(16'h47C2, 8'h13, 1'b0, 1'b1);
        probe(16'hC000, 1'b0, 1'b1, "R2 mirror 47C2");
        bus_write(16'h4C0C, 8'h85, 1'b0, 1'b1);
        probe(16'h8000, 1'b0, 1'b1, "R2 mirror 4C0C");

        // R3: stray cycles must not change register 2
        bus_write(16'h4002, 8'h1E, 1'b0, 1'b1);
        probe(16'hC000, 1'b0, 1'b1, "R3 A10 clear");
        bus_write(16'h4C12, 8'h1E, 1'b0, 1'b1);
        probe(16'hC000, 1'b0, 1'b1, "R3 A4 set");
        bus_write(16'h4C22, 8'h1E, 1'b0, 1'b1);
        probe(16'hC000, 1'b0, 1'b1, "R3 A5 set");
        bus_write(16'h5C02, 8'h1E, 1'b0, 1'b1);
        probe(16'hC000, 1'b0, 1'b1, "R3 A12 set");
        bus_write(16'h4C02, 8'h1E, 1'b1, 1'b1);
        probe(16'hC000, 1'b0, 1'b1, "R3 read cycle");
        bus_write(16'h4C02, 8'h1E, 1'b0, 1'b0);
        probe(16'hC000, 1'b0, 1'b1, "R3 romsel low");

        // R4: last write wins, commit on first clock with M2 low
        @(negedge clk);
        cpu_addr = 16'h4C02; cpu_data = 8'h07; cpu_rw = 1'b0; romsel_n = 1'b1; m2 = 1'b1;
        @(negedge clk);
        cpu_data = 8'h09;
        @(negedge clk);
        cpu_rw = 1'b1; romsel_n = 1'b0; cpu_addr = 16'hC000;
        #1 compare("R4 before fall", {mreg[2][4:0], 3'b011});
        @(negedge clk);
        m2 = 1'b0;
        #1 compare("R4 M2 low before edge", {mreg[2][4:0], 3'b011});
        @(negedge clk);
        #1 compare("R4 after commit edge", {5'h09, 3'b011});
        mreg[2] = 8'h09;
        romsel_n = 1'b1;
        probe(16'hC000, 1'b0, 1'b1, "R4 committed value");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule